// File: doc/BRIEF.md
# Receive Byte Queue

This block sits between a serial receiver's deserializer and the register port that software reads. It holds up to four received bytes in arrival order. The line side offers bytes through a valid/ready push port, and ready is withheld while the receiver is disabled or the queue is full. The register side removes the oldest byte with a one-cycle pop strobe, and the byte at the head is always visible on the data output.

A line break is handled on its own input. It always enters the queue as a zero byte, even when the receiver is disabled. When the queue is already full, the break byte replaces the newest entry, so the break is never lost. Each break also produces a one-cycle flag pulse for the interrupt logic.

A flush input, driven by the receiver-reset command, empties the queue in one cycle. All state uses a synchronous active-high reset.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty: `not_empty`=0, `full`=0, `brk_flag`=0 and `head_data`=0x00.
- R2: Bytes leave the queue in the order they were accepted. `head_data` shows the oldest byte in the cycle after the push or pop that changed it.
- R3: `push_ready` is high exactly when `rx_en`=1, `full`=0 and `brk_evt`=0. A `push_valid` without `push_ready` stores nothing.
- R4: An accepted push sets `not_empty` in the next cycle. `full` rises in the cycle after the fourth entry is stored, and `full` never appears without `not_empty`.
- R5: A pop on a non-empty queue removes one entry and clears `full`. Removing the last entry clears `not_empty`.
- R6: A pop on an empty queue changes no state, and `head_data` reads 0x00 whenever the queue is empty.
- R7: `brk_evt` stores a 0x00 byte whatever the value of `rx_en`. `brk_flag` is high for exactly the one cycle after each break cycle.
- R8: A break that arrives on a full queue with no pop overwrites the newest entry. The queue stays full and the older three entries keep their order.
- R9: `flush` empties the queue and clears `not_empty` and `full` in the next cycle. A push or break in the same cycle is not stored, but the break still pulses `brk_flag`.
- R10: A push and a pop in the same cycle remove the old head and append the new byte, leaving the count unchanged. A break together with a pop on a full queue is appended normally. A pop on an empty queue in the same cycle as a push leaves exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enabled; gates line-side pushes |
| push_valid | input | 1 | Line side offers a byte |
| push_data | input | 8 | Offered byte |
| push_ready | output | 1 | Queue accepts a byte this cycle |
| brk_evt | input | 1 | Line break detected this cycle |
| pop | input | 1 | Data-register read strobe; removes the head |
| flush | input | 1 | Receiver reset command; empties the queue |
| head_data | output | 8 | Oldest byte, 0x00 when empty |
| not_empty | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |
| brk_flag | output | 1 | One-cycle pulse after a break |

## Verification
The checker watches these relations on every cycle:
- The flags stay consistent with each other.
- Ready is withheld while full.
- The head reads zero when empty.
- The queue is empty after a flush.
- A break always pulses the flag.
- A full queue stays full through a break without a pop.

Byte ordering, the overwrite of the newest entry, and the exact contents after simultaneous push and pop can only be shown by the bench's scenarios. These scenarios drain the queue and compare every byte against an expected sequence.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_act_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  // Plain array without reset so the tools may map it to RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             push_valid,
  input  logic             brk_evt,
  input  logic             pop,
  input  logic             flush,
  output logic             push_ready,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] rd_addr,
  output logic             not_empty,
  output logic             full,
  output logic             brk_flag
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_n, rd_ptr_n, wr_prev;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ne_q, full_q, brk_q;
  logic             push_acc, pop_acc, ingest;
  wr_act_e          act;

  assign push_ready = rx_en && !full_q && !brk_evt;
  assign push_acc   = push_valid && push_ready;
  assign pop_acc    = pop && (cnt_q != '0);
  assign ingest     = push_acc || brk_evt;

  always_comb begin
    if (flush || !ingest)         act = WR_NONE;
    else if (full_q && !pop_acc)  act = WR_REPLACE;
    else                          act = WR_APPEND;
  end

  assign wr_prev = (wr_ptr_q == '0) ? LAST_PTR : wr_ptr_q - 1'b1;
  assign wr_addr = (act == WR_REPLACE) ? wr_prev : wr_ptr_q;
  assign wr_en   = (act != WR_NONE);
  assign rd_addr = rd_ptr_q;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (act == WR_APPEND)
        wr_ptr_n = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_acc)
        rd_ptr_n = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      cnt_n = cnt_q + CNT_W'(act == WR_APPEND) - CNT_W'(pop_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ne_q     <= 1'b0;
      full_q   <= 1'b0;
      brk_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
      ne_q     <= (cnt_n != '0);
      full_q   <= (cnt_n == FULL_CNT);
      brk_q    <= brk_evt;
    end
  end

  assign not_empty = ne_q;
  assign full      = full_q;
  assign brk_flag  = brk_q;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              brk_evt,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] head_data,
  output logic              not_empty,
  output logic              full,
  output logic              brk_flag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign wr_data = brk_evt ? '0 : push_data;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .push_valid (push_valid),
    .brk_evt    (brk_evt),
    .pop        (pop),
    .flush      (flush),
    .push_ready (push_ready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .not_empty  (not_empty),
    .full       (full),
    .brk_flag   (brk_flag)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign head_data = not_empty ? rd_data : '0;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              push_valid,
  input logic [DATA_W-1:0] push_data,
  input logic              push_ready,
  input logic              brk_evt,
  input logic              pop,
  input logic              flush,
  input logic [DATA_W-1:0] head_data,
  input logic              not_empty,
  input logic              full,
  input logic              brk_flag
);
  // R4
  full_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> not_empty);

  // R3
  no_ready_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !push_ready);

  // R6
  empty_head_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !not_empty |-> (head_data == '0));

  // R6
  empty_pop_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && pop && !(push_valid && push_ready) && !brk_evt) |=> !not_empty);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!not_empty && !full));

  // R7
  brk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> brk_flag);

  // R7
  brk_pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_evt |=> !brk_flag);

  // R8
  brk_full_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full && brk_evt && !pop && !flush) |=> full);

  wire unused_ok = rx_en ^ (^push_data);
endmodule

bind rx_byte_queue rxq_checker #(.DATA_W(DATA_W)) chk (.*);

// File: tb/rx_byte_queue_test.sv
`timescale 1ns/1ps
module rx_byte_queue_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, push_valid = 1'b0, brk_evt = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       push_ready, not_empty, full, brk_flag;
  logic [7:0] head_data;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rx_byte_queue uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
    .push_data(push_data), .push_ready(push_ready), .brk_evt(brk_evt),
    .pop(pop), .flush(flush), .head_data(head_data),
    .not_empty(not_empty), .full(full), .brk_flag(brk_flag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one cycle from a negedge and returns at the next negedge.
  task automatic cyc(input logic pv, input logic [7:0] pd, input logic br,
                     input logic pp, input logic fl);
    push_valid = pv; push_data = pd; brk_evt = br; pop = pp; flush = fl;
    @(negedge clk);
    push_valid = 1'b0; brk_evt = 1'b0; pop = 1'b0; flush = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);  cyc(1'b1, d, 1'b0, 1'b0, 1'b0); endtask

  task automatic pop_expect(input string tag, input logic [7:0] exp);
    chk(tag, head_data, exp);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic empty_now();
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 not_empty", not_empty, 0);
    chk("R1 full", full, 0);
    chk("R1 brk_flag", brk_flag, 0);
    chk("R1 head", head_data, 8'h00);
  endtask

  task automatic t_order();
    rx_en = 1'b1;
    @(negedge clk);
    chk("R3 ready idle", push_ready, 1);
    push(8'hA1); chk("R4 not_empty", not_empty, 1); chk("R2 head", head_data, 8'hA1);
    push(8'hB2); push(8'hC3);
    chk("R4 not full at 3", full, 0);
    push(8'hD4);
    chk("R4 full at 4", full, 1);
    chk("R3 ready when full", push_ready, 0);
    push(8'h55);
    chk("R3 ignored push head", head_data, 8'hA1);
    pop_expect("R2 first", 8'hA1);
    chk("R5 full cleared", full, 0);
    pop_expect("R2 second", 8'hB2);
    pop_expect("R2 third", 8'hC3);
    pop_expect("R2 fourth", 8'hD4);
    chk("R5 not_empty cleared", not_empty, 0);
    chk("R6 head empty", head_data, 8'h00);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    @(negedge clk);
    chk("R3 ready disabled", push_ready, 0);
    push(8'h77);
    chk("R3 disabled push dropped", not_empty, 0);
    rx_en = 1'b1;
    @(negedge clk);
    push_valid = 1'b1; brk_evt = 1'b1; #0.5;
    chk("R3 ready during break", push_ready, 0);
    push_valid = 1'b0; brk_evt = 1'b0;
  endtask

  task automatic t_empty_pop();
    rx_en = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R6 empty pop not_empty", not_empty, 0);
    chk("R6 empty pop head", head_data, 8'h00);
    push(8'h11);
    pop_expect("R6 after empty pop", 8'h11);
    chk("R6 single entry drained", not_empty, 0);
  endtask

  task automatic t_break();
    rx_en = 1'b0;
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R7 brk_flag pulse", brk_flag, 1);
    chk("R7 break stored", not_empty, 1);
    chk("R7 break byte", head_data, 8'h00);
    @(negedge clk);
    chk("R7 brk_flag one cycle", brk_flag, 0);
    empty_now();
  endtask

  task automatic t_break_full();
    rx_en = 1'b1;
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R8 still full", full, 1);
    pop_expect("R8 e0", 8'h01);
    pop_expect("R8 e1", 8'h02);
    pop_expect("R8 e2", 8'h03);
    pop_expect("R8 newest replaced", 8'h00);
    chk("R8 drained", not_empty, 0);
  endtask

  task automatic t_flush();
    rx_en = 1'b1;
    push(8'h31); push(8'h32);
    cyc(1'b1, 8'h33, 1'b0, 1'b0, 1'b1);
    chk("R9 flush not_empty", not_empty, 0);
    chk("R9 flush full", full, 0);
    chk("R9 flush head", head_data, 8'h00);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    chk("R9 flush beats break", not_empty, 0);
    chk("R9 break flag still pulses", brk_flag, 1);
    push(8'h9A);
    pop_expect("R9 after flush", 8'h9A);
  endtask

  task automatic t_simul();
    rx_en = 1'b1;
    cyc(1'b1, 8'h20, 1'b0, 1'b1, 1'b0);
    chk("R10 pop empty plus push", not_empty, 1);
    chk("R10 pop empty plus push head", head_data, 8'h20);
    cyc(1'b1, 8'h22, 1'b0, 1'b1, 1'b0);
    chk("R10 swap head", head_data, 8'h22);
    chk("R10 swap count", not_empty, 1);
    push(8'h23); push(8'h24); push(8'h25);
    chk("R10 full before", full, 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R10 full after pop+break", full, 1);
    pop_expect("R10 s0", 8'h23);
    pop_expect("R10 s1", 8'h24);
    pop_expect("R10 s2", 8'h25);
    pop_expect("R10 break appended", 8'h00);
    chk("R10 drained", not_empty, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_disabled();
    t_empty_pop();
    t_break();
    t_break_full();
    t_flush();
    t_simul();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule